// File: doc/BRIEF.md
# Video Interrupt Status Register

This block keeps the interrupt state of a video controller in one byte. Two sources feed it, each as a single-cycle strobe: a scan-line event and a once-per-second event. Each strobe sets its own status bit, and each source has its own enable bit. A master pending bit and the interrupt output go high when some source has both its status and its enable bit set.

Status bits record events even when their source is disabled, so software can poll a source without taking interrupts from it. The processor side has three operations. It can read the whole byte. A control write loads the two enable bits. A clear write drops status bits: a zero in a status position clears that bit, and a one leaves it as it is. The master bit is registered and follows the status and enable bits with one cycle of delay.

Top module: `vid_irq_reg`

## Requirements
- R1: After reset, the byte reads 0x00 and `irq_o` is low.
- R2: A `line_evt_i` strobe sets bit 5 (scan-line status) at the next clock edge, whether or not bit 1 is set.
- R3: A `sec_evt_i` strobe sets bit 6 (one-second status) at the next clock edge, whether or not bit 2 is set.
- R4: On a clear write (`clr_we_i`), a zero in `wdata_i[5]` or `wdata_i[6]` clears that status bit. A one leaves that bit unchanged. The enable bits are not affected.
- R5: On a control write (`ctl_we_i`), bit 2 (one-second enable) and bit 1 (scan-line enable) take the values of `wdata_i[2]` and `wdata_i[1]`. The status bits are not affected. Without a control write, the enable bits hold their values.
- R6: Bit 7 is a register. After every clock edge it equals the OR of (bit 6 AND bit 2) and (bit 5 AND bit 1), taken from the byte's value before that edge.
- R7: `irq_o` always equals bit 7.
- R8: Bits 4, 3 and 0 always read zero, and nothing written to them has any effect.
- R9: If a source strobe and a clear of the same status bit arrive in the same cycle, the strobe wins and the bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_evt_i | input | 1 | Scan-line event strobe |
| sec_evt_i | input | 1 | One-second event strobe |
| ctl_we_i | input | 1 | Control write: load the enable bits from wdata_i |
| clr_we_i | input | 1 | Clear write: zeros in wdata_i status positions clear those bits |
| wdata_i | input | 8 | Processor write data |
| rdata_o | output | 8 | Register byte as read |
| irq_o | output | 1 | Interrupt request, equal to bit 7 |

## Verification
Directed cases come first:
- Events that arrive while their enable is off show that status is kept apart from the interrupt.
- Clear bytes with mixed zeros and ones show that the zero-clears convention works on each bit separately.
- A strobe and a clear of the same bit in the same cycle fix which one has priority.
- Enabling a source whose status is already pending, and then disabling it, measures the one-cycle lag of the master bit in both directions.

After that, random mixes of strobes, control writes and clear writes with random data bytes are run against a bench model. These catch errors in how overlapping operations combine, and any reserved bit that leaks through.

// File: rtl/vid_irq_pkg.sv
package vid_irq_pkg;
  localparam int DATA_W     = 8;
  localparam int N_SRC      = 2;  // 0: scan line, 1: one second
  localparam int STAT_LSB   = 5;
  localparam int EN_LSB     = 1;
  localparam int MASTER_BIT = 7;
endpackage

// File: rtl/vid_irq_src.sv
module vid_irq_src (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic clr_we_i,
  input  logic keep_i,
  input  logic ctl_we_i,
  input  logic en_d_i,
  output logic stat_o,
  output logic en_o
);
  logic stat_q, en_q;

  // event has priority over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= 1'b0;
    end else if (evt_i) begin
      stat_q <= 1'b1;
    end else if (clr_we_i && !keep_i) begin
      stat_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0;
    end else if (ctl_we_i) begin
      en_q <= en_d_i;
    end
  end

  assign stat_o = stat_q;
  assign en_o   = en_q;
endmodule

// File: rtl/vid_irq_master.sv
module vid_irq_master #(
  parameter int N_SRC = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] stat_i,
  input  logic [N_SRC-1:0] en_i,
  output logic             pend_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= |(stat_i & en_i);
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/vid_irq_reg.sv
module vid_irq_reg
  import vid_irq_pkg::*;
#(
  parameter int DW    = DATA_W,
  parameter int NS    = N_SRC,
  parameter int S_LSB = STAT_LSB,
  parameter int E_LSB = EN_LSB,
  parameter int M_BIT = MASTER_BIT
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          line_evt_i,
  input  logic          sec_evt_i,
  input  logic          ctl_we_i,
  input  logic          clr_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);
  logic [NS-1:0] evt, stat, en;
  logic          pend;

  assign evt = NS'({sec_evt_i, line_evt_i});

  for (genvar i = 0; i < NS; i++) begin : g_src
    vid_irq_src u_src (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .evt_i    (evt[i]),
      .clr_we_i (clr_we_i),
      .keep_i   (wdata_i[S_LSB+i]),
      .ctl_we_i (ctl_we_i),
      .en_d_i   (wdata_i[E_LSB+i]),
      .stat_o   (stat[i]),
      .en_o     (en[i])
    );
  end

  vid_irq_master #(.N_SRC(NS)) u_master (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stat_i (stat),
    .en_i   (en),
    .pend_o (pend)
  );

  always_comb begin
    rdata_o        = '0;
    rdata_o[M_BIT] = pend;
    for (int i = 0; i < NS; i++) begin
      rdata_o[S_LSB+i] = stat[i];
      rdata_o[E_LSB+i] = en[i];
    end
  end

  assign irq_o = pend;
endmodule

// File: rtl/vid_irq_reg_chk.sv
module vid_irq_reg_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       line_evt_i,
  input logic       sec_evt_i,
  input logic       ctl_we_i,
  input logic       clr_we_i,
  input logic [7:0] wdata_i,
  input logic [7:0] rdata_o,
  input logic       irq_o
);
  p_line_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_evt_i |=> rdata_o[5]);

  p_sec_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_evt_i |=> rdata_o[6]);

  p_clr_line_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && !wdata_i[5] && !line_evt_i) |=> !rdata_o[5]);

  p_clr_en_keep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_we_i |=> $stable(rdata_o[2:1]));

  p_ctl_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_we_i |=> rdata_o[2:1] == $past(wdata_i[2:1]));

  p_master_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> rdata_o[7] == $past(|(rdata_o[6:5] & rdata_o[2:1])));

  p_irq_eq_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == rdata_o[7]);

  p_resv_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o[4:3] == 2'b00) && !rdata_o[0]);

  p_evt_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_evt_i && clr_we_i && !wdata_i[6]) |=> rdata_o[6]);
endmodule

bind vid_irq_reg vid_irq_reg_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .line_evt_i (line_evt_i),
  .sec_evt_i  (sec_evt_i),
  .ctl_we_i   (ctl_we_i),
  .clr_we_i   (clr_we_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .irq_o      (irq_o)
);

// File: tb/sim_vid_irq_reg.sv
`timescale 1ns/1ps
module sim_vid_irq_reg;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       line_evt_i = 1'b0, sec_evt_i = 1'b0;
  logic       ctl_we_i = 1'b0, clr_we_i = 1'b0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic       irq_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // bench model
  bit m_ls, m_ss, m_le, m_se, m_p;

  always #10 clk_i = ~clk_i;

  vid_irq_reg u0 (.*);

  function automatic logic [7:0] exp_byte();
    return {m_p, m_ss, m_ls, 2'b00, m_se, m_le, 1'b0};
  endfunction

  function automatic void model_step(bit le, bit se, bit cw, bit kw, logic [7:0] d);
    bit np;
    np = (m_ls & m_le) | (m_ss & m_se);
    if (le) m_ls = 1'b1; else if (kw && !d[5]) m_ls = 1'b0;
    if (se) m_ss = 1'b1; else if (kw && !d[6]) m_ss = 1'b0;
    if (cw) begin m_le = d[1]; m_se = d[2]; end
    m_p = np;
  endfunction

  task automatic chk(string tag);
    logic [7:0] e;
    e = exp_byte();
    checks++;
    if (rdata_o !== e) begin
      errors++;
      $display("FAIL %s rdata act=%02h exp=%02h", tag, rdata_o, e);
    end
    checks++;
    if (irq_o !== e[7]) begin
      errors++;
      $display("FAIL R7 irq act=%0b exp=%0b", irq_o, e[7]);
    end
  endtask

  // drive after negedge, clock, check at next negedge
  task automatic step(bit le, bit se, bit cw, bit kw, logic [7:0] d, string tag);
    line_evt_i = le; sec_evt_i = se; ctl_we_i = cw; clr_we_i = kw; wdata_i = d;
    @(posedge clk_i);
    model_step(le, se, cw, kw, d);
    @(negedge clk_i);
    line_evt_i = 0; sec_evt_i = 0; ctl_we_i = 0; clr_we_i = 0; wdata_i = 8'h00;
    chk(tag);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    {m_ls, m_ss, m_le, m_se, m_p} = '0;
    repeat (3) @(negedge clk_i);
    chk("R1 reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 after release");

    // events while disabled: status only
    step(1, 0, 0, 0, 8'h00, "R2 line disabled");
    step(0, 0, 0, 0, 8'h00, "R2 hold");
    step(0, 1, 0, 0, 8'h00, "R3 sec disabled");
    // reserved bits written
    step(0, 0, 1, 0, 8'h19, "R8 reserved ctl");
    step(0, 0, 0, 1, 8'hFF, "R8 clear all ones keeps");
    // enable line source with pending status: master lags one cycle
    step(0, 0, 1, 0, 8'h02, "R5 enable line");
    step(0, 0, 0, 0, 8'h00, "R6 master rises");
    // clear only sec status (zero at bit 6, one at bit 5)
    step(0, 0, 0, 1, 8'h20, "R4 clear sec only");
    // disable line source; master falls one cycle later
    step(0, 0, 1, 0, 8'hE0, "R5 disable, status kept");
    step(0, 0, 0, 0, 8'h00, "R6 master falls");
    // clear line, with control bits in data ignored
    step(0, 0, 0, 1, 8'h46, "R4 clear line, enables unchanged");
    // event beats clear
    step(1, 1, 0, 1, 8'h00, "R9 event wins");
    step(0, 0, 1, 0, 8'h04, "R5 enable sec");
    step(0, 0, 0, 1, 8'h00, "R4 clear both");
    step(0, 0, 0, 0, 8'h00, "R6 master drops");

    for (int i = 0; i < 3000; i++) begin
      logic [7:0] d;
      bit le, se, cw, kw;
      d  = 8'($urandom);
      le = ($urandom % 5) == 0;
      se = ($urandom % 7) == 0;
      cw = ($urandom % 4) == 0;
      kw = ($urandom % 4) == 0;
      step(le, se, cw, kw, d, "R2 R3 R4 R5 R6 R8 R9 random");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule